// File: doc/BRIEF.md
# Role-Selected Symbol Sign Scrambler

This block sits in the transmit path of a four-pair gigabit copper link, after the stage that maps data to quinary symbols. It keeps a 33-bit linear feedback shift register that steps once for each accepted symbol quartet. The feedback taps depend on whether the link end acts as timing master or slave. Four fixed register bits form a 4-bit scrambler word. Each bit of the word decides whether the symbol on its lane leaves negated or unchanged. Only the sign changes, never the magnitude, so the symbol alphabet {-2, -1, 0, +1, +2} is kept.

A small two-state controller tracks the symbol stream. In `ST_IDLE` no quartet was accepted in the previous cycle. In `ST_ACTIVE` one was. The transition `IDLE->ACTIVE` happens when `sym_valid` is high. The transition `ACTIVE->IDLE` happens when it is low. Each state otherwise holds. `out_valid` is high exactly in `ST_ACTIVE`. A software-supplied seed can restart the register at any time. An all-zero seed would lock the register, so the block refuses it.

Top module: `ssc_top`

## Requirements
- R1: While `rst_n` is low, the register takes the seed 0x1_0ACE_1357. `sym_out` clears to zero and `out_valid` clears to 0.
- R2: With `role_master` = 1, a cycle with `sym_valid` high and no accepted load shifts the register up one place (bit k+1 takes bit k). The new bit 0 is bit 32 XOR bit 12.
- R3: With `role_master` = 0, the same step uses bit 32 XOR bit 19 as the new bit 0.
- R4: With `sym_valid` low and no accepted load, the register and `scr_word` hold.
- R5: `seed_load` high with a nonzero `seed_val` replaces the register with `seed_val` on the next edge, and takes priority over any step in that cycle.
- R6: `seed_load` with an all-zero `seed_val` is ignored. The register then holds, or steps if `sym_valid` is high.
- R7: `scr_word` bits 0, 1, 2 and 3 equal register bits 0, 3, 8 and 12. They serve lanes A, B, C and D, which sit at `sym_in`/`sym_out` bits [2:0], [5:3], [8:6] and [11:9].
- R8: One cycle after a quartet is accepted, each lane of `sym_out` equals the two's-complement negation of its input if the matching `scr_word` bit was 1 in the accepting cycle. If that bit was 0, the lane equals its input. A zero input gives zero.
- R9: `out_valid` equals `sym_valid` delayed by one cycle. `sym_out` holds while no quartet is accepted.
- R10: In either role, the register never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_master | input | 1 | 1 selects master feedback, 0 selects slave feedback |
| seed_load | input | 1 | Request to replace the register with `seed_val` |
| seed_val | input | 33 | Seed value, ignored when zero |
| sym_valid | input | 1 | A symbol quartet is present on `sym_in` |
| sym_in | input | 12 | Four signed 3-bit symbols, lane A in the low bits |
| sym_out | output | 12 | Four sign-scrambled signed 3-bit symbols, registered |
| out_valid | output | 1 | `sym_out` was updated on the last edge |
| scr_word | output | 4 | Sign-control word taken from the current register state |

## Verification
The bench builds the block with its default parameters: four lanes of 3-bit symbols, a 33-bit register, and taps at 13 and 20. A software model of the register runs in step with it. Under this configuration, a sweep over all 625 input quartets in each role checks the sign rule on every lane and every symbol value, zero included. Long runs of twenty thousand steps per role, with gaps, role changes, accepted seeds and refused seeds, follow the `scr_word` sequence far enough to expose a wrong tap. They also show that the word never freezes at zero, as it would if the register locked up.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Stream tracking states of the top-level controller
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ssc_phase_e;

endpackage

// File: rtl/ssc_lfsr.sv
module ssc_lfsr #(
    parameter int            W          = 33,
    parameter int            MASTER_TAP = 13,
    parameter int            SLAVE_TAP  = 20,
    parameter logic [W-1:0]  SEED_RST   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master_i,
    input  logic         adv_i,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);

    localparam int MIDX = MASTER_TAP - 1;
    localparam int SIDX = SLAVE_TAP - 1;

    logic [W-1:0] state_q;
    logic         seed_ok;
    logic         fb;

    assign seed_ok = load_i && (seed_i != '0);
    assign fb      = state_q[W-1] ^ (master_i ? state_q[MIDX] : state_q[SIDX]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED_RST;
        end else if (seed_ok) begin
            state_q <= seed_i;
        end else if (adv_i) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/ssc_sign_lane.sv
module ssc_sign_lane #(
    parameter int SYM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             flip_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] sym_o
);

    logic [SYM_W-1:0] q;
    logic [SYM_W-1:0] neg;

    // two's-complement negation; zero maps to zero
    assign neg = ~sym_i + SYM_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en_i) begin
            q <= flip_i ? neg : sym_i;
        end
    end

    assign sym_o = q;

endmodule

// File: rtl/ssc_top.sv
module ssc_top
    import ssc_pkg::*;
#(
    parameter int                   LANES      = 4,
    parameter int                   SYM_W      = 3,
    parameter int                   LFSR_W     = 33,
    parameter int                   MASTER_TAP = 13,
    parameter int                   SLAVE_TAP  = 20,
    parameter logic [LFSR_W-1:0]    RESET_SEED = 33'h1_0ACE_1357,
    parameter logic [LANES*8-1:0]   SIGN_TAPS  = 32'h0C_08_03_00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    role_master,
    input  logic                    seed_load,
    input  logic [LFSR_W-1:0]       seed_val,
    input  logic                    sym_valid,
    input  logic [LANES*SYM_W-1:0]  sym_in,
    output logic [LANES*SYM_W-1:0]  sym_out,
    output logic                    out_valid,
    output logic [LANES-1:0]        scr_word
);

    logic [LFSR_W-1:0] lfsr_q;
    ssc_phase_e        st_q;
    ssc_phase_e        st_d;

    ssc_lfsr #(
        .W          (LFSR_W),
        .MASTER_TAP (MASTER_TAP),
        .SLAVE_TAP  (SLAVE_TAP),
        .SEED_RST   (RESET_SEED)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_i (role_master),
        .adv_i    (sym_valid),
        .load_i   (seed_load),
        .seed_i   (seed_val),
        .state_o  (lfsr_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int TAP_G = int'(SIGN_TAPS[g*8 +: 8]);

        assign scr_word[g] = lfsr_q[TAP_G];

        ssc_sign_lane #(
            .SYM_W (SYM_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (sym_valid),
            .flip_i (scr_word[g]),
            .sym_i  (sym_in[g*SYM_W +: SYM_W]),
            .sym_o  (sym_out[g*SYM_W +: SYM_W])
        );
    end

    // stream controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // stream controller: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = sym_valid ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE: st_d = sym_valid ? ST_ACTIVE : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // stream controller: outputs
    always_comb begin
        out_valid = (st_q == ST_ACTIVE);
    end

endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
    parameter int LANES      = 4,
    parameter int SYM_W      = 3,
    parameter int LFSR_W     = 33,
    parameter int MASTER_TAP = 13,
    parameter int SLAVE_TAP  = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   role_master,
    input logic                   seed_load,
    input logic [LFSR_W-1:0]      seed_val,
    input logic                   sym_valid,
    input logic [LANES*SYM_W-1:0] sym_in,
    input logic [LANES*SYM_W-1:0] sym_out,
    input logic                   out_valid,
    input logic [LFSR_W-1:0]      state
);

    localparam int MIDX = MASTER_TAP - 1;
    localparam int SIDX = SLAVE_TAP - 1;

    logic accept_seed;
    assign accept_seed = seed_load && (seed_val != '0);

    // R2: master step
    a_r2_master_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !accept_seed && role_master) |=>
            (state[LFSR_W-1:1] == $past(state[LFSR_W-2:0])) &&
            (state[0] == ($past(state[LFSR_W-1]) ^ $past(state[MIDX]))));

    // R3: slave step
    a_r3_slave_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !accept_seed && !role_master) |=>
            (state[LFSR_W-1:1] == $past(state[LFSR_W-2:0])) &&
            (state[0] == ($past(state[LFSR_W-1]) ^ $past(state[SIDX]))));

    // R4: hold without valid
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !seed_load) |=> $stable(state));

    // R5: accepted seed
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        accept_seed |=> (state == $past(seed_val)));

    // R6: zero seed refused
    a_r6_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && (seed_val == '0) && !sym_valid) |=> $stable(state));

    // R9: valid follows input by one cycle
    a_r9_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> out_valid);
    a_r9_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (!out_valid && $stable(sym_out)));

    // R10: register never locks at zero
    a_r10_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    // R8: magnitude preserved per lane
    for (genvar g = 0; g < LANES; g++) begin : g_mag
        a_r8_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
            sym_valid |=>
                (sym_out[g*SYM_W +: SYM_W] == $past(sym_in[g*SYM_W +: SYM_W])) ||
                (sym_out[g*SYM_W +: SYM_W] == (~$past(sym_in[g*SYM_W +: SYM_W]) + SYM_W'(1))));
    end

endmodule

bind ssc_top ssc_chk #(
    .LANES      (LANES),
    .SYM_W      (SYM_W),
    .LFSR_W     (LFSR_W),
    .MASTER_TAP (MASTER_TAP),
    .SLAVE_TAP  (SLAVE_TAP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_master (role_master),
    .seed_load   (seed_load),
    .seed_val    (seed_val),
    .sym_valid   (sym_valid),
    .sym_in      (sym_in),
    .sym_out     (sym_out),
    .out_valid   (out_valid),
    .state       (lfsr_q)
);

// File: tb/tb_ssc_top.sv
module tb_ssc_top;

    localparam logic [32:0] SEED_DEF = 33'h1_0ACE_1357;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_master = 1'b1;
    logic        seed_load = 1'b0;
    logic [32:0] seed_val = '0;
    logic        sym_valid = 1'b0;
    logic [11:0] sym_in = '0;
    logic [11:0] sym_out;
    logic        out_valid;
    logic [3:0]  scr_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [32:0] mdl;
    logic [11:0] exp_out = '0;
    logic        exp_ov  = 1'b0;
    int          zero_run = 0;
    int          zero_max = 0;

    always #5 clk = ~clk;

    ssc_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_master (role_master),
        .seed_load   (seed_load),
        .seed_val    (seed_val),
        .sym_valid   (sym_valid),
        .sym_in      (sym_in),
        .sym_out     (sym_out),
        .out_valid   (out_valid),
        .scr_word    (scr_word)
    );

    function automatic logic [32:0] step_m(input logic [32:0] s, input logic m);
        logic fb;
        fb = s[32] ^ (m ? s[12] : s[19]);
        return {s[31:0], fb};
    endfunction

    function automatic logic [3:0] word_m(input logic [32:0] s);
        return {s[12], s[8], s[3], s[0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // apply one cycle of inputs at a falling edge, then check at the next one
    task automatic cyc(input logic v, input logic ld, input logic [32:0] sd,
                       input logic m, input logic [11:0] syms, input string tag);
        logic [3:0] w;
        w = word_m(mdl);
        sym_valid = v; seed_load = ld; seed_val = sd; role_master = m; sym_in = syms;
        if (v) begin
            for (int i = 0; i < 4; i++) begin
                logic [2:0] x;
                x = syms[i*3 +: 3];
                exp_out[i*3 +: 3] = w[i] ? (~x + 3'd1) : x;
            end
        end
        exp_ov = v;
        if (ld && sd != '0) mdl = sd;
        else if (v)         mdl = step_m(mdl, m);
        @(negedge clk);
        check(scr_word == word_m(mdl), {tag, "/R7 word"}, 64'(scr_word), 64'(word_m(mdl)));
        check(out_valid == exp_ov, "R9 out_valid", 64'(out_valid), 64'(exp_ov));
        check(sym_out == exp_out, "R8 sym_out", 64'(sym_out), 64'(exp_out));
        if (scr_word == 4'd0) zero_run++; else zero_run = 0;
        if (zero_run > zero_max) zero_max = zero_run;
    endtask

    function automatic logic [11:0] quartet(input int code);
        logic [11:0] r;
        int c;
        c = code;
        for (int i = 0; i < 4; i++) begin
            r[i*3 +: 3] = 3'((c % 5) - 2);
            c = c / 5;
        end
        return r;
    endfunction

    task automatic sweep(input logic m, input string tag);
        for (int k = 0; k < 625; k++) begin
            cyc(1'b1, 1'b0, '0, m, quartet(k), tag);
            if (k % 97 == 0) cyc(1'b0, 1'b0, '0, m, quartet(k + 1), "R4");
        end
    endtask

    task automatic long_run(input logic m, input string tag);
        for (int k = 0; k < 20000; k++) begin
            logic v;
            v = ($urandom % 8) != 0;
            cyc(v, 1'b0, '0, m, quartet(int'($urandom % 625)), tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl = SEED_DEF;
        @(negedge clk);
        // R1: reset state
        check(scr_word == word_m(SEED_DEF), "R1 word", 64'(scr_word), 64'(word_m(SEED_DEF)));
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(sym_out == '0, "R1 sym_out", 64'(sym_out), 64'd0);

        // R4: idle cycles hold
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, '0, 1'b1, 12'h0A5, "R4");

        // R2: master sweep over every quartet
        sweep(1'b1, "R2");

        // R5: seed loads, alone and together with a valid quartet
        cyc(1'b0, 1'b1, 33'h0_0000_0001, 1'b1, '0, "R5");
        for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, '0, 1'b1, quartet(k * 13), "R2");
        cyc(1'b1, 1'b1, 33'h1_FFFF_FFFF, 1'b1, quartet(311), "R5");
        cyc(1'b1, 1'b0, '0, 1'b1, quartet(7), "R2");

        // R6: zero seed refused, with and without valid
        cyc(1'b0, 1'b1, '0, 1'b1, quartet(3), "R6");
        cyc(1'b1, 1'b1, '0, 1'b0, quartet(400), "R6");

        // R3: slave sweep over every quartet
        sweep(1'b0, "R3");

        // R10: long runs in each role, the word must never freeze at zero
        long_run(1'b1, "R2");
        cyc(1'b0, 1'b1, 33'h1_2000_0000, 1'b0, '0, "R5");
        long_run(1'b0, "R3");
        check(zero_max < 33, "R10 zero run", 64'(zero_max), 64'd32);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule